// File: doc/BRIEF.md
# Type 0 Configuration Header Register File

This block holds the 64-byte standard header that every PCI function presents in configuration space. It serves configuration reads and writes that arrive already decoded to a dword register number (6 bits, covering the full 256-byte function space), four byte enables and a 32-bit data word. Reads return data through a registered port. Writes change the writable header fields lane by lane.

The identification fields, class code, subsystem IDs, capability pointer and interrupt pin are build-time parameters and cannot be written. Software may write the command enables, cache line size, latency timer, interrupt line and three base address windows. Each window is fixed at build time as memory or I/O, with a power-of-two size between 16 bytes and 2 GB. The address bits below the window size read back as zero, so writing all ones and reading back reveals the size.

Error pulses from the bus logic set sticky status flags, which software clears by writing ones. The command enables, the timing bytes and the decoded window bases are driven out to the rest of the function.

Top module: `cfg_header_regs`

## Requirements
- R1: Dwords 0 (device ID 3C4Dh in bits 31:16, vendor ID 1A2Bh in bits 15:0), 2 (class 0B4000h in bits 31:8, revision 05h in bits 7:0), 11 (subsystem ID 7081h high, subsystem vendor 5E6Fh low) and 13 (capability pointer 40h in bits 7:0, rest zero) read their fixed values, and writes to them change nothing.
- R2: Dwords 7, 8, 9, 10, 12, 14 and 16 through 63 read as zero, and writes to them change no other register or output.
- R3: A read issued with rd_en in one cycle returns its data on rd_data with rd_valid high in the next cycle, and rd_valid is low in a cycle that follows no read.
- R4: In the command half of dword 1 (bits 15:0), only bit 0 (I/O enable), bit 1 (memory enable), bit 2 (bus master), bit 6 (parity response), bit 8 (system error enable) and bit 10 (interrupt disable) can be written. Each is written only when its byte enable is set, and each drives its own output.
- R5: Window 0 is memory, 4 KB, at dword 4. Window 1 is I/O, 16 bytes, at dword 5. Window 2 is memory, 2 GB, at dword 6. Writing FFFFFFFFh reads back FFFFF000h, FFFFFFF1h and 80000000h respectively. Bit 0 reads 1 only for I/O.
- R6: A window write updates only the byte lanes whose enable is set, and the window's base output equals its stored address bits.
- R7: Status flags in dword 1 are: bit 31 parity detected, bit 30 system error signalled, bit 29 master abort received, bit 28 target abort received, bit 27 target abort signalled, bit 24 master data parity error. An event pulse sets its flag. Writing 1 with byte enable 3 clears the flag, and writing 0 or leaving the lane disabled does not. When an event and a clear fall in the same cycle, the flag stays set.
- R8: Status bit 20 (capability list) reads 1 when the capability pointer is nonzero. Bits 26:25 (select timing) read 01b. Bit 21 (66 MHz capable) reads 0.
- R9: At dword 3, bits 7:0 (cache line size) and bits 15:8 (latency timer) can be written per lane and drive outputs. Header type and self-test bytes read zero.
- R10: At dword 15, the interrupt line in bits 7:0 can be written. Interrupt pin 01h (bits 15:8), minimum grant 02h (bits 23:16) and maximum latency 08h (bits 31:24) are fixed.
- R11: Synchronous reset clears the command bits, all window bases, the status flags, cache line size, latency timer, interrupt line and rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Configuration read strobe |
| wr_en | input | 1 | Configuration write strobe |
| reg_idx | input | 6 | Dword register number |
| byte_en | input | 4 | Byte lane enables for writes |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| ev_par_det | input | 1 | Parity error detected pulse |
| ev_serr_sig | input | 1 | System error signalled pulse |
| ev_mabort_rcv | input | 1 | Master abort received pulse |
| ev_tabort_rcv | input | 1 | Target abort received pulse |
| ev_tabort_sig | input | 1 | Target abort signalled pulse |
| ev_mdpe | input | 1 | Master data parity error pulse |
| io_en | output | 1 | I/O space enable |
| mem_en | output | 1 | Memory space enable |
| master_en | output | 1 | Bus master enable |
| perr_resp_en | output | 1 | Parity error response enable |
| serr_en | output | 1 | System error reporting enable |
| int_disable | output | 1 | Interrupt disable |
| cache_line_size | output | 8 | Cache line size byte |
| latency_timer | output | 8 | Latency timer byte |
| bar0_base | output | 32 | Window 0 base address |
| bar1_base | output | 32 | Window 1 base address |
| bar2_base | output | 32 | Window 2 base address |

## Verification
Read data and rd_valid are due exactly one cycle after the cycle that holds rd_en. Writes and event pulses change registers and outputs at the same clock edge that samples them. The bench drives every stimulus at a falling edge. Each read pushes its expected word into a scoreboard queue at the moment it is driven. A monitor pops the queue at the next falling edge, where rd_valid must be high. Direct outputs are compared at the falling edge after the write's sampling edge, so every comparison lands half a cycle after the register it observes has settled.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;

    typedef logic [5:0] dw_idx_t;

    localparam dw_idx_t DW_ID      = 6'd0;
    localparam dw_idx_t DW_CMDSTAT = 6'd1;
    localparam dw_idx_t DW_CLASS   = 6'd2;
    localparam dw_idx_t DW_MISC    = 6'd3;
    localparam dw_idx_t DW_BAR0    = 6'd4;
    localparam dw_idx_t DW_BAR1    = 6'd5;
    localparam dw_idx_t DW_BAR2    = 6'd6;
    localparam dw_idx_t DW_SUBSYS  = 6'd11;
    localparam dw_idx_t DW_CAP     = 6'd13;
    localparam dw_idx_t DW_INTR    = 6'd15;

    localparam int NUM_BARS = 3;

    // writable command bits: 0,1,2,6,8,10
    localparam logic [15:0] CMD_WR_MASK = 16'h0547;
    // sticky error flags in the status half: 15,14,13,12,11,8
    localparam logic [15:0] ERR_MASK    = 16'hF900;

    typedef struct packed {
        logic int_disable;
        logic serr_en;
        logic perr_resp;
        logic master_en;
        logic mem_en;
        logic io_en;
    } cmd_bits_t;

    typedef struct packed {
        logic par_det;
        logic serr_sig;
        logic mabort_rcv;
        logic tabort_rcv;
        logic tabort_sig;
        logic mdpe;
    } err_events_t;

    function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                               input logic [31:0] new_w,
                                               input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] bar_addr_mask(input int log2sz);
        return 32'hFFFF_FFFF << log2sz;
    endfunction

    function automatic cmd_bits_t cmd_decode(input logic [15:0] w);
        cmd_bits_t c;
        c.io_en       = w[0];
        c.mem_en      = w[1];
        c.master_en   = w[2];
        c.perr_resp   = w[6];
        c.serr_en     = w[8];
        c.int_disable = w[10];
        return c;
    endfunction

    function automatic logic [15:0] err_to_word(input err_events_t e);
        logic [15:0] w;
        w     = '0;
        w[15] = e.par_det;
        w[14] = e.serr_sig;
        w[13] = e.mabort_rcv;
        w[12] = e.tabort_rcv;
        w[11] = e.tabort_sig;
        w[8]  = e.mdpe;
        return w;
    endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfghdr_pkg::*;
#(
    parameter bit IS_IO     = 1'b0,
    parameter int LOG2_SIZE = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] base,
    output logic [31:0] rdata
);
    localparam logic [31:0] ADDR_MASK = bar_addr_mask(LOG2_SIZE);
    localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h0000_0001 : 32'h0000_0000;

    logic [31:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (wr_hit) begin
            base_q <= lane_merge(base_q, wdata, be) & ADDR_MASK;
        end
    end

    assign base  = base_q;
    assign rdata = base_q | TYPE_BITS;
endmodule

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status
    import cfghdr_pkg::*;
#(
    parameter bit CAP_PRESENT = 1'b1,
    parameter bit FAST66      = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  err_events_t events,
    output cmd_bits_t   cmd,
    output logic [15:0] cmd_word,
    output logic [15:0] status_word
);
    // select timing medium (01b at bits 10:9), 66 MHz at bit 5, caps at bit 4
    localparam logic [15:0] STAT_FIXED = 16'h0200
                                       | (FAST66 ? 16'h0020 : 16'h0000)
                                       | (CAP_PRESENT ? 16'h0010 : 16'h0000);

    logic [15:0] cmd_q;
    logic [15:0] err_q;
    logic [31:0] cmd_merged;
    logic [15:0] clr_word;
    logic [15:0] set_word;

    always_comb begin
        cmd_merged = lane_merge({16'h0000, cmd_q}, wdata, be);
        clr_word   = wr_hit ? (wdata[31:16] & {{8{be[3]}}, {8{be[2]}}}) : 16'h0000;
        set_word   = err_to_word(events);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            err_q <= '0;
        end else begin
            if (wr_hit) begin
                cmd_q <= cmd_merged[15:0] & CMD_WR_MASK;
            end
            err_q <= ((err_q & ~clr_word) | set_word) & ERR_MASK;
        end
    end

    assign cmd         = cmd_decode(cmd_q);
    assign cmd_word    = cmd_q;
    assign status_word = err_q | STAT_FIXED;
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
    import cfghdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID   = 16'h3C4D,
    parameter logic [7:0]  REVISION    = 8'h05,
    parameter logic [23:0] CLASS_CODE  = 24'h0B4000,
    parameter logic [15:0] SUBSYS_VID  = 16'h5E6F,
    parameter logic [15:0] SUBSYS_ID   = 16'h7081,
    parameter logic [7:0]  CAP_PTR     = 8'h40,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    parameter logic [7:0]  MIN_GNT     = 8'h02,
    parameter logic [7:0]  MAX_LAT     = 8'h08,
    parameter bit          FAST66      = 1'b0,
    parameter logic [2:0]  BAR_IS_IO   = 3'b010,
    parameter int          BAR0_LOG2   = 12,
    parameter int          BAR1_LOG2   = 4,
    parameter int          BAR2_LOG2   = 31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [5:0]  reg_idx,
    input  logic [3:0]  byte_en,
    input  logic [31:0] wr_data,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    input  logic        ev_par_det,
    input  logic        ev_serr_sig,
    input  logic        ev_mabort_rcv,
    input  logic        ev_tabort_rcv,
    input  logic        ev_tabort_sig,
    input  logic        ev_mdpe,
    output logic        io_en,
    output logic        mem_en,
    output logic        master_en,
    output logic        perr_resp_en,
    output logic        serr_en,
    output logic        int_disable,
    output logic [7:0]  cache_line_size,
    output logic [7:0]  latency_timer,
    output logic [31:0] bar0_base,
    output logic [31:0] bar1_base,
    output logic [31:0] bar2_base
);
    localparam bit CAP_PRESENT = (CAP_PTR != 8'h00);

    logic [31:0] bar_base_w [NUM_BARS];
    logic [31:0] bar_rd_w   [NUM_BARS];

    cmd_bits_t   cmd_w;
    logic [15:0] cmd_word_w;
    logic [15:0] status_w;
    err_events_t events_w;

    logic [7:0]  cls_q;
    logic [7:0]  lat_q;
    logic [7:0]  intline_q;
    logic [31:0] misc_merged;
    logic [31:0] intr_merged;
    logic [31:0] rd_word;

    assign events_w = '{par_det:    ev_par_det,
                        serr_sig:   ev_serr_sig,
                        mabort_rcv: ev_mabort_rcv,
                        tabort_rcv: ev_tabort_rcv,
                        tabort_sig: ev_tabort_sig,
                        mdpe:       ev_mdpe};

    cfg_cmd_status #(
        .CAP_PRESENT (CAP_PRESENT),
        .FAST66      (FAST66)
    ) u_cmd_status (
        .clk         (clk),
        .rst         (rst),
        .wr_hit      (wr_en && (reg_idx == DW_CMDSTAT)),
        .be          (byte_en),
        .wdata       (wr_data),
        .events      (events_w),
        .cmd         (cmd_w),
        .cmd_word    (cmd_word_w),
        .status_word (status_w)
    );

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        localparam int      SLOT_LOG2 = (i == 0) ? BAR0_LOG2 :
                                        (i == 1) ? BAR1_LOG2 : BAR2_LOG2;
        localparam dw_idx_t SLOT_IDX  = DW_BAR0 + dw_idx_t'(i);

        cfg_bar_slot #(
            .IS_IO     (BAR_IS_IO[i]),
            .LOG2_SIZE (SLOT_LOG2)
        ) u_slot (
            .clk    (clk),
            .rst    (rst),
            .wr_hit (wr_en && (reg_idx == SLOT_IDX)),
            .be     (byte_en),
            .wdata  (wr_data),
            .base   (bar_base_w[i]),
            .rdata  (bar_rd_w[i])
        );
    end

    always_comb begin
        misc_merged = lane_merge({16'h0000, lat_q, cls_q}, wr_data, byte_en);
        intr_merged = lane_merge({24'h000000, intline_q}, wr_data, byte_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q     <= '0;
            lat_q     <= '0;
            intline_q <= '0;
        end else if (wr_en) begin
            if (reg_idx == DW_MISC) begin
                cls_q <= misc_merged[7:0];
                lat_q <= misc_merged[15:8];
            end
            if (reg_idx == DW_INTR) begin
                intline_q <= intr_merged[7:0];
            end
        end
    end

    always_comb begin
        case (reg_idx)
            DW_ID:      rd_word = {DEVICE_ID, VENDOR_ID};
            DW_CMDSTAT: rd_word = {status_w, cmd_word_w};
            DW_CLASS:   rd_word = {CLASS_CODE, REVISION};
            DW_MISC:    rd_word = {16'h0000, lat_q, cls_q};
            DW_BAR0:    rd_word = bar_rd_w[0];
            DW_BAR1:    rd_word = bar_rd_w[1];
            DW_BAR2:    rd_word = bar_rd_w[2];
            DW_SUBSYS:  rd_word = {SUBSYS_ID, SUBSYS_VID};
            DW_CAP:     rd_word = {24'h000000, CAP_PTR};
            DW_INTR:    rd_word = {MAX_LAT, MIN_GNT, INT_PIN, intline_q};
            default:    rd_word = 32'h0000_0000;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_word;
            end
        end
    end

    assign io_en           = cmd_w.io_en;
    assign mem_en          = cmd_w.mem_en;
    assign master_en       = cmd_w.master_en;
    assign perr_resp_en    = cmd_w.perr_resp;
    assign serr_en         = cmd_w.serr_en;
    assign int_disable     = cmd_w.int_disable;
    assign cache_line_size = cls_q;
    assign latency_timer   = lat_q;
    assign bar0_base       = bar_base_w[0];
    assign bar1_base       = bar_base_w[1];
    assign bar2_base       = bar_base_w[2];
endmodule

// File: rtl/cfg_header_regs_chk.sv
module cfg_header_regs_chk
    import cfghdr_pkg::*;
#(
    parameter int BAR0_LOG2 = 12,
    parameter int BAR1_LOG2 = 4,
    parameter int BAR2_LOG2 = 31
) (
    input logic        clk,
    input logic        rst,
    input logic        rd_en,
    input logic        wr_en,
    input logic        rd_valid,
    input logic        ev_par_det,
    input logic        ev_mabort_rcv,
    input logic [15:0] status_word,
    input logic [5:0]  cmd_outs,
    input logic [31:0] bar0_base,
    input logic [31:0] bar1_base,
    input logic [31:0] bar2_base
);
    localparam logic [31:0] M0 = bar_addr_mask(BAR0_LOG2);
    localparam logic [31:0] M1 = bar_addr_mask(BAR1_LOG2);
    localparam logic [31:0] M2 = bar_addr_mask(BAR2_LOG2);

    logic rst_q = 1'b0;
    always @(posedge clk) rst_q <= rst;

    a_r3_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    a_r4_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cmd_outs));

    a_r6_bar_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({bar0_base, bar1_base, bar2_base}));

    a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        ((bar0_base & ~M0) == 0) && ((bar1_base & ~M1) == 0) && ((bar2_base & ~M2) == 0));

    a_r7_parity_sets: assert property (@(posedge clk) disable iff (rst)
        ev_par_det |=> status_word[15]);

    a_r7_mabort_sets: assert property (@(posedge clk) disable iff (rst)
        ev_mabort_rcv |=> status_word[13]);

    always @(posedge clk) begin
        if (rst_q) begin
            a_r11_reset_clears: assert (cmd_outs == 6'b0 && bar0_base == 32'h0 &&
                                        bar1_base == 32'h0 && bar2_base == 32'h0 &&
                                        status_word[15:11] == 5'b0 && !status_word[8])
                else $error("R11 reset state not clear");
        end
    end
endmodule

bind cfg_header_regs cfg_header_regs_chk #(
    .BAR0_LOG2 (BAR0_LOG2),
    .BAR1_LOG2 (BAR1_LOG2),
    .BAR2_LOG2 (BAR2_LOG2)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .rd_valid      (rd_valid),
    .ev_par_det    (ev_par_det),
    .ev_mabort_rcv (ev_mabort_rcv),
    .status_word   (status_w),
    .cmd_outs      ({int_disable, serr_en, perr_resp_en, master_en, mem_en, io_en}),
    .bar0_base     (bar0_base),
    .bar1_base     (bar1_base),
    .bar2_base     (bar2_base)
);

// File: tb/cfg_header_regs_tb.sv
module cfg_header_regs_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  reg_idx = '0;
    logic [3:0]  byte_en = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    // {par_det, serr_sig, mabort_rcv, tabort_rcv, tabort_sig, mdpe}
    logic [5:0]  ev = '0;
    logic        io_en, mem_en, master_en, perr_resp_en, serr_en, int_disable;
    logic [7:0]  cache_line_size, latency_timer;
    logic [31:0] bar0_base, bar1_base, bar2_base;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_header_regs u_dut (
        .clk (clk), .rst (rst), .rd_en (rd_en), .wr_en (wr_en),
        .reg_idx (reg_idx), .byte_en (byte_en), .wr_data (wr_data),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .ev_par_det (ev[5]), .ev_serr_sig (ev[4]), .ev_mabort_rcv (ev[3]),
        .ev_tabort_rcv (ev[2]), .ev_tabort_sig (ev[1]), .ev_mdpe (ev[0]),
        .io_en (io_en), .mem_en (mem_en), .master_en (master_en),
        .perr_resp_en (perr_resp_en), .serr_en (serr_en), .int_disable (int_disable),
        .cache_line_size (cache_line_size), .latency_timer (latency_timer),
        .bar0_base (bar0_base), .bar1_base (bar1_base), .bar2_base (bar2_base)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = idx; byte_en = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; byte_en = '0;
    endtask

    task automatic cfg_read(input logic [5:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; reg_idx = idx;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] m);
        @(negedge clk);
        ev = m;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // scoreboard monitor: read data is due one cycle after rd_en
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R3 unexpected rd_valid: actual=1 expected=0");
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check("R11 command outputs", {26'h0, int_disable, serr_en, perr_resp_en, master_en, mem_en, io_en}, 32'h0);
        check("R11 bar0 base", bar0_base, 32'h0);
        check("R11 bar1 base", bar1_base, 32'h0);
        check("R3 idle rd_valid", {31'h0, rd_valid}, 32'h0);
        cfg_read(6'd1, 32'h0210_0000, "R11/R8 cmd+status after reset");
        cfg_read(6'd3, 32'h0000_0000, "R11 timing bytes after reset");

        // R1 fixed identity
        cfg_write(6'd0, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'd2, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'd11, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'd13, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd0, 32'h3C4D_1A2B, "R1 ids");
        cfg_read(6'd2, 32'h0B40_0005, "R1 class/rev");
        cfg_read(6'd11, 32'h7081_5E6F, "R1 subsystem");
        cfg_read(6'd13, 32'h0000_0040, "R1 cap pointer");

        // R5 sizing
        cfg_write(6'd4, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'd5, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'd6, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd4, 32'hFFFF_F000, "R5 bar0 size 4KB mem");
        cfg_read(6'd5, 32'hFFFF_FFF1, "R5 bar1 size 16B io");
        cfg_read(6'd6, 32'h8000_0000, "R5 bar2 size 2GB mem");
        check("R6 bar1 base output", bar1_base, 32'hFFFF_FFF0);

        // R6 byte lanes
        cfg_write(6'd4, 4'hF, 32'h0000_0000);
        cfg_write(6'd4, 4'b1100, 32'hABCD_EF12);
        check("R6 bar0 upper lanes", bar0_base, 32'hABCD_0000);
        cfg_write(6'd4, 4'b0010, 32'h0000_5678);
        check("R6 bar0 lane1 masked", bar0_base, 32'hABCD_5000);
        cfg_read(6'd4, 32'hABCD_5000, "R6 bar0 readback");

        // R2 unimplemented dwords
        for (int k = 0; k < 9; k++) begin
            logic [5:0] idx;
            case (k)
                0: idx = 6'd7;  1: idx = 6'd8;  2: idx = 6'd9;
                3: idx = 6'd10; 4: idx = 6'd12; 5: idx = 6'd14;
                6: idx = 6'd16; 7: idx = 6'd40; default: idx = 6'd63;
            endcase
            cfg_write(idx, 4'hF, 32'hFFFF_FFFF);
            cfg_read(idx, 32'h0, "R2 unimplemented reads zero");
        end
        check("R2 bar0 untouched", bar0_base, 32'hABCD_5000);
        check("R2 bar2 untouched", bar2_base, 32'h8000_0000);

        // R4 command
        cfg_write(6'd1, 4'b0011, 32'h0000_FFFF);
        check("R4 all enables set", {26'h0, int_disable, serr_en, perr_resp_en, master_en, mem_en, io_en}, 32'h3F);
        cfg_read(6'd1, 32'h0210_0547, "R4 command readback");
        cfg_write(6'd1, 4'b0010, 32'h0000_0000);
        check("R4 lane1 clear only", {26'h0, int_disable, serr_en, perr_resp_en, master_en, mem_en, io_en}, 32'h0F);

        // R7 status flags
        pulse(6'b101000);
        cfg_read(6'd1, 32'hA210_0047, "R7 par+mabort set");
        cfg_write(6'd1, 4'b1000, 32'h2000_0000);
        cfg_read(6'd1, 32'h8210_0047, "R7 W1C mabort");
        cfg_write(6'd1, 4'b0100, 32'h8000_0000);
        cfg_write(6'd1, 4'b1000, 32'h0000_0000);
        cfg_read(6'd1, 32'h8210_0047, "R7 disabled lane and zero write keep flag");
        @(negedge clk);
        ev = 6'b100000; wr_en = 1'b1; reg_idx = 6'd1; byte_en = 4'b1000; wr_data = 32'h8000_0000;
        @(negedge clk);
        ev = '0; wr_en = 1'b0; byte_en = '0;
        cfg_read(6'd1, 32'h8210_0047, "R7 set wins over clear");
        pulse(6'b010111);
        cfg_read(6'd1, 32'hDB10_0047, "R7 other flags set");
        cfg_write(6'd1, 4'b1000, 32'hFF00_0000);
        cfg_read(6'd1, 32'h0210_0047, "R7/R8 all cleared, fixed bits stay");

        // R9 timing bytes
        cfg_write(6'd3, 4'hF, 32'hFFFF_FFFF);
        check("R9 cache line out", {24'h0, cache_line_size}, 32'hFF);
        check("R9 latency out", {24'h0, latency_timer}, 32'hFF);
        cfg_read(6'd3, 32'h0000_FFFF, "R9 readback");
        cfg_write(6'd3, 4'b0010, 32'h0000_0022);
        cfg_read(6'd3, 32'h0000_00FF, "R9 lane1 only");

        // R10 interrupt dword
        cfg_write(6'd15, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd15, 32'h0802_01FF, "R10 intr dword");

        // R11 reset again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 outputs after reset", {26'h0, int_disable, serr_en, perr_resp_en, master_en, mem_en, io_en}, 32'h0);
        check("R11 bar2 after reset", bar2_base, 32'h0);
        check("R11 timing after reset", {16'h0, latency_timer, cache_line_size}, 32'h0);
        cfg_read(6'd15, 32'h0802_0100, "R11 intr line cleared");
        cfg_read(6'd4, 32'h0000_0000, "R11 bar0 cleared");

        repeat (3) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        finish_run();
    end
endmodule